// File: doc/BRIEF.md
# Burst Address Window Guard

This block sits beside a bus path to memory and decides, combinationally, whether a pending read burst and a pending write burst may proceed. It looks at each burst's start address, beat count and beat size. Software programs it through a small register file behind an AXI4-Lite slave port. That register file holds one control word and ten window descriptors.

Each descriptor opens a naturally aligned window whose size is a power of two. A descriptor may grant reads only, or reads and writes. A burst is granted only when every byte it touches lies inside a single enabled window. The two bits of the control word can refuse all reads or all writes, whatever the windows say. Separate channel logic, outside this block, uses the two grant flags to forward a burst or to block it.

Top module: `burst_window_guard`

## Requirements
- R1: After reset every register reads as zero and neither grant flag is asserted.
- R2: A register at offset 0x00 (control) or 0x04 + 4*k for k = 0..9 (window k) stores the written data under the byte strobes and reads back the stored value. Every write and read is answered with response code 0 (OKAY).
- R3: A read at any offset above 0x28 returns zero. A write there changes no register and no grant.
- R4: Control bit 0 set refuses every read burst. Control bit 1 set refuses every write burst.
- R5: A window whose bit 0 (enable) is clear grants nothing.
- R6: An enabled window whose bit 1 (write permit) is clear grants read bursts and no write bursts.
- R7: A window with size code x in bits 8:4 spans 2^(x+2) bytes. Its base is bits 31:12 of the descriptor, placed at address bits 31:12, with the low x+2 address bits cleared. The base is therefore aligned to at least 4 KB.
- R8: A burst spans ((len+1) << size) bytes from its start address. It is granted by a window only when the start is at or above the window base and the last byte is at or below the window's top address.
- R9: Size codes 30 and 31 cover the whole 32-bit space. A burst whose last byte would pass address 0xFFFFFFFF is refused.
- R10: A burst is granted when any one window grants it; windows combine by OR.
- R11: A write or read response, once raised, holds steady until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awaddr | input | LITE_AW | Register write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Register write data |
| s_wstrb | input | 4 | Byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | LITE_AW | Register read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| rd_addr | input | 32 | Start address of pending read burst |
| rd_len | input | LEN_W | Read beats minus one |
| rd_size | input | SIZE_W | Read beat size, log2 bytes |
| rd_ok | output | 1 | Read burst granted |
| wr_addr | input | 32 | Start address of pending write burst |
| wr_len | input | LEN_W | Write beats minus one |
| wr_size | input | SIZE_W | Write beat size, log2 bytes |
| wr_ok | output | 1 | Write burst granted |

## Verification
The hardest cases to reach from the ports are bursts that sit exactly on a window edge: the last byte equal to the window top, one byte past it, and a burst that runs off the end of the 32-bit space. These come from hand-picked descriptors with small, mid and full-space size codes, paired with burst lengths chosen to land on each edge. A random phase then places burst starts near the programmed window bases. It uses random lengths, sizes, permissions and deny bits, and a behavioural model checks both grant flags on every clock.

// File: rtl/burst_window_guard.sv
module burst_window_guard #(
  parameter int NUM_WIN = 10,
  parameter int LITE_AW = 8,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3
) (
  input  logic               aclk,
  input  logic               aresetn,
  input  logic [LITE_AW-1:0] s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [31:0]        s_wdata,
  input  logic [3:0]         s_wstrb,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [LITE_AW-1:0] s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [31:0]        s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rvalid,
  input  logic               s_rready,
  input  logic [31:0]        rd_addr,
  input  logic [LEN_W-1:0]   rd_len,
  input  logic [SIZE_W-1:0]  rd_size,
  output logic               rd_ok,
  input  logic [31:0]        wr_addr,
  input  logic [LEN_W-1:0]   wr_len,
  input  logic [SIZE_W-1:0]  wr_size,
  output logic               wr_ok
);
  localparam int NREG  = NUM_WIN + 1;
  localparam int IDX_W = LITE_AW - 2;
  localparam int CNT_W = LEN_W + 1 + (2**SIZE_W - 1);

  logic [31:0] regs [NREG];
  logic [IDX_W-1:0] widx, ridx;
  logic wr_fire, rd_fire;
  logic [31:0] rd_word;

  wire unused_lo = &{1'b0, s_awaddr[1:0], s_araddr[1:0]};

  assign widx = s_awaddr[LITE_AW-1:2];
  assign ridx = s_araddr[LITE_AW-1:2];

  assign wr_fire   = s_awvalid & s_wvalid & ~s_bvalid;
  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign s_arready = ~s_rvalid;
  assign rd_fire   = s_arvalid & ~s_rvalid;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (32'(ridx) == i) rd_word = regs[i];
  end

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      s_bvalid <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      if (wr_fire) begin
        for (int i = 0; i < NREG; i++)
          if (32'(widx) == i)
            for (int b = 0; b < 4; b++)
              if (s_wstrb[b]) regs[i][8*b +: 8] <= s_wdata[8*b +: 8];
        s_bvalid <= 1'b1;
      end else if (s_bready) begin
        s_bvalid <= 1'b0;
      end
      if (rd_fire) begin
        s_rdata  <= rd_word;
        s_rvalid <= 1'b1;
      end else if (s_rready) begin
        s_rvalid <= 1'b0;
      end
    end
  end

  logic [CNT_W-1:0] rd_cnt, wr_cnt;
  logic [32:0] rd_last, wr_last;

  assign rd_cnt  = (CNT_W'(rd_len) + CNT_W'(1)) << rd_size;
  assign wr_cnt  = (CNT_W'(wr_len) + CNT_W'(1)) << wr_size;
  assign rd_last = {1'b0, rd_addr} + 33'(rd_cnt) - 33'd1;
  assign wr_last = {1'b0, wr_addr} + 33'(wr_cnt) - 33'd1;

  logic [NUM_WIN-1:0] rd_hit, wr_hit;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [5:0]  expo;
    logic [31:0] mask, base, top;
    assign expo = 6'(regs[g+1][8:4]) + 6'd2;
    assign mask = (expo >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << expo) - 32'd1);
    assign base = {regs[g+1][31:12], 12'h000} & ~mask;
    assign top  = base | mask;
    assign rd_hit[g] = regs[g+1][0] && (rd_addr >= base) && (rd_last <= {1'b0, top});
    assign wr_hit[g] = regs[g+1][0] && regs[g+1][1] &&
                       (wr_addr >= base) && (wr_last <= {1'b0, top});
  end

  assign rd_ok = ~regs[0][0] & |rd_hit;
  assign wr_ok = ~regs[0][1] & |wr_hit;

  // R11
  b_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid && !s_bready |=> s_bvalid);
  // R11
  r_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  // R2
  b_follow_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_awvalid && s_awready |=> s_bvalid && s_bresp == 2'b00);
  // R6
  wr_implies_rd_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    wr_ok && rd_addr == wr_addr && rd_len == wr_len && rd_size == wr_size
    |-> rd_ok || regs[0][0]);
  // R9
  rd_nowrap_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    rd_ok |-> (33'(rd_addr) + 33'(rd_cnt) <= 33'h1_0000_0000));
  // R9
  wr_nowrap_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    wr_ok |-> (33'(wr_addr) + 33'(wr_cnt) <= 33'h1_0000_0000));
endmodule

// File: tb/burst_window_guard_bench.sv
`timescale 1ns/1ps
module burst_window_guard_bench;
  logic aclk = 0, aresetn = 0;
  logic [7:0] s_awaddr = 0, s_araddr = 0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_wdata = 0;
  logic [3:0] s_wstrb = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [31:0] rd_addr = 0, wr_addr = 0;
  logic [7:0] rd_len = 0, wr_len = 0;
  logic [2:0] rd_size = 0, wr_size = 0;
  logic rd_ok, wr_ok;

  int checks = 0, fails = 0;
  bit cmp_en = 0;
  string cur_req = "R1";
  logic [31:0] m_regs [11];

  always #2 aclk = ~aclk;

  burst_window_guard u_burst_window_guard (.*);

  function automatic bit model_grant(bit is_wr, logic [31:0] a, logic [7:0] l, logic [2:0] s);
    longint cnt, last, mask, base, top;
    int e;
    bit hit = 0;
    cnt  = (longint'(l) + 1) << s;
    last = longint'(a) + cnt - 1;
    for (int k = 1; k <= 10; k++) begin
      e = int'(m_regs[k][8:4]) + 2;
      mask = (e >= 32) ? 64'hFFFF_FFFF : ((64'd1 << e) - 1);
      base = (longint'(m_regs[k][31:12]) << 12) & ~mask & 64'hFFFF_FFFF;
      top  = base | mask;
      if (m_regs[k][0] && (!is_wr || m_regs[k][1]) && longint'(a) >= base && last <= top)
        hit = 1;
    end
    if (is_wr) return hit && !m_regs[0][1];
    return hit && !m_regs[0][0];
  endfunction

  task automatic chk(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  always begin
    @(negedge aclk);
    #1;
    if (cmp_en) begin
      chk(cur_req, rd_ok == model_grant(0, rd_addr, rd_len, rd_size), 32'(rd_ok),
          32'(model_grant(0, rd_addr, rd_len, rd_size)));
      chk(cur_req, wr_ok == model_grant(1, wr_addr, wr_len, wr_size), 32'(wr_ok),
          32'(model_grant(1, wr_addr, wr_len, wr_size)));
    end
  end

  task automatic lite_wr(logic [7:0] a, logic [31:0] d, logic [3:0] st = 4'hF, int hold = 0);
    @(negedge aclk);
    s_awaddr = a; s_wdata = d; s_wstrb = st; s_awvalid = 1; s_wvalid = 1;
    @(posedge aclk);
    #1;
    if (a[7:2] <= 10)
      for (int b = 0; b < 4; b++)
        if (st[b]) m_regs[a[7:2]][8*b +: 8] = d[8*b +: 8];
    @(negedge aclk);
    s_awvalid = 0; s_wvalid = 0;
    chk("R2", s_bvalid && s_bresp == 2'b00, {30'd0, s_bresp}, 32'd0);
    for (int h = 0; h < hold; h++) begin
      @(negedge aclk);
      chk("R11", s_bvalid == 1'b1, 32'(s_bvalid), 32'd1);
    end
    s_bready = 1;
    @(negedge aclk);
    s_bready = 0;
  endtask

  task automatic lite_rd(logic [7:0] a, output logic [31:0] d, input int hold = 0);
    logic [31:0] first;
    @(negedge aclk);
    s_araddr = a; s_arvalid = 1;
    @(negedge aclk);
    s_arvalid = 0;
    chk("R2", s_rvalid && s_rresp == 2'b00, {30'd0, s_rresp}, 32'd0);
    first = s_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge aclk);
      chk("R11", s_rvalid && s_rdata == first, s_rdata, first);
    end
    d = s_rdata;
    s_rready = 1;
    @(negedge aclk);
    s_rready = 0;
  endtask

  task automatic burst(string req, logic [31:0] a, logic [7:0] l, logic [2:0] s, bit er, bit ew);
    @(negedge aclk);
    rd_addr = a; rd_len = l; rd_size = s;
    wr_addr = a; wr_len = l; wr_size = s;
    #1;
    chk(req, rd_ok == er, 32'(rd_ok), 32'(er));
    chk(req, wr_ok == ew, 32'(wr_ok), 32'(ew));
  endtask

  function automatic logic [31:0] win(logic [19:0] f, int x, bit w);
    return {f, 12'h000} | (32'(x) << 4) | (32'(w) << 1) | 32'd1;
  endfunction

  initial begin
    repeat (200000) @(posedge aclk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 11; k++) m_regs[k] = 0;
    repeat (3) @(posedge aclk);
    @(negedge aclk);
    aresetn = 1;
    // R1
    for (int k = 0; k < 12; k++) begin
      lite_rd(8'(4*k), d);
      chk("R1", d == 0, d, 0);
    end
    burst("R1", 32'h0, 8'd0, 3'd0, 0, 0);
    cmp_en = 1;

    cur_req = "R8";
    lite_wr(8'h04, win(20'h40000, 10, 1));
    lite_rd(8'h04, d); chk("R2", d == win(20'h40000, 10, 1), d, win(20'h40000, 10, 1));
    burst("R8", 32'h4000_0FF0, 8'd3, 3'd2, 1, 1);
    burst("R8", 32'h4000_0FF0, 8'd4, 3'd2, 0, 0);
    burst("R8", 32'h3FFF_FFFC, 8'd0, 3'd2, 0, 0);

    cur_req = "R4";
    lite_wr(8'h00, 32'h1);
    burst("R4", 32'h4000_0000, 8'd0, 3'd2, 0, 1);
    lite_wr(8'h00, 32'h2);
    burst("R4", 32'h4000_0000, 8'd0, 3'd2, 1, 0);
    lite_wr(8'h00, 32'h0);

    cur_req = "R6";
    lite_wr(8'h04, win(20'h40000, 10, 0));
    burst("R6", 32'h4000_0100, 8'd1, 3'd3, 1, 0);
    cur_req = "R5";
    lite_wr(8'h04, win(20'h40000, 10, 1) & ~32'h1);
    burst("R5", 32'h4000_0100, 8'd1, 3'd3, 0, 0);

    cur_req = "R7";
    lite_wr(8'h08, win(20'h12345, 0, 1));
    burst("R7", 32'h1234_5000, 8'd0, 3'd2, 1, 1);
    burst("R7", 32'h1234_5004, 8'd0, 3'd2, 0, 0);
    burst("R7", 32'h1234_5000, 8'd1, 3'd2, 0, 0);
    lite_wr(8'h0C, win(20'h12345, 14, 1));
    burst("R7", 32'h1234_0000, 8'd255, 3'd7, 1, 1);
    burst("R8", 32'h1234_C000, 8'd255, 3'd7, 0, 0);
    burst("R7", 32'h1234_F000, 8'd0, 3'd0, 1, 1);

    cur_req = "R9";
    lite_wr(8'h28, win(20'h00000, 31, 0));
    lite_rd(8'h28, d); chk("R2", d == win(20'h0, 31, 0), d, win(20'h0, 31, 0));
    burst("R9", 32'hFFFF_FFFC, 8'd0, 3'd2, 1, 0);
    burst("R9", 32'hFFFF_FFFC, 8'd1, 3'd2, 0, 0);
    lite_wr(8'h28, win(20'hABCDE, 30, 1));
    burst("R9", 32'h0000_0010, 8'd3, 3'd1, 1, 1);
    lite_wr(8'h28, 32'h0);

    cur_req = "R10";
    lite_wr(8'h10, win(20'h80000, 10, 0));
    lite_wr(8'h14, win(20'h90000, 10, 1));
    burst("R10", 32'h9000_0100, 8'd0, 3'd0, 1, 1);
    burst("R10", 32'h8000_0100, 8'd0, 3'd0, 1, 0);

    cur_req = "R3";
    lite_wr(8'h2C, 32'hFFFF_FFFF);
    lite_wr(8'h3C, 32'hFFFF_FFFF);
    lite_rd(8'h2C, d); chk("R3", d == 0, d, 0);
    lite_rd(8'h30, d); chk("R3", d == 0, d, 0);
    lite_rd(8'h00, d); chk("R3", d == 0, d, 0);
    burst("R3", 32'h8000_0100, 8'd0, 3'd0, 1, 0);

    cur_req = "R2";
    lite_wr(8'h18, 32'hAABB_CCDD);
    lite_wr(8'h18, 32'h1111_1111, 4'b0010);
    lite_rd(8'h18, d); chk("R2", d == 32'hAABB_11DD, d, 32'hAABB_11DD);
    lite_wr(8'h18, 32'h0);

    cur_req = "R11";
    lite_wr(8'h1C, 32'h5555_0000, 4'hF, 3);
    lite_rd(8'h1C, d, 3); chk("R11", d == 32'h5555_0000, d, 32'h5555_0000);

    cur_req = "R10";
    for (int it = 0; it < 150; it++) begin
      int k;
      logic [31:0] a, v;
      k = 1 + int'($urandom_range(0, 9));
      v = $urandom;
      v[8:4] = 5'($urandom_range(0, 20));
      if ($urandom_range(0, 7) == 0) v[8:4] = 5'($urandom_range(28, 31));
      lite_wr(8'(4*k), v);
      if ($urandom_range(0, 9) == 0) lite_wr(8'h00, 32'($urandom_range(0, 3)));
      for (int j = 0; j < 4; j++) begin
        @(negedge aclk);
        k = 1 + int'($urandom_range(0, 9));
        a = {m_regs[k][31:12], 12'h000} + 32'($urandom_range(0, 70000)) - 32'd64;
        rd_addr = a; rd_len = 8'($urandom); rd_size = 3'($urandom);
        wr_addr = a + 32'($urandom_range(0, 1) * 4096);
        wr_len = 8'($urandom); wr_size = 3'($urandom);
      end
    end
    repeat (2) @(negedge aclk);
    cmp_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule